// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Controller

This controller sits between seven active-low interrupt request lines and a processor that runs interrupt-acknowledge bus cycles. Levels 1 to 6 can be blocked by a 3-bit priority mask. Level 7 cannot be blocked. The controller reports whether an interrupt is pending and which level currently wins. When the processor runs an acknowledge cycle, the controller reads the level being acknowledged from the CPU-space address. It then answers with exactly one of three responses: the device's vector byte, an internal autovector termination, or a spurious-interrupt response.

Each of levels 1 to 6 is set to one of two modes:
- Level-sensitive: the line must stay low until its acknowledge.
- Edge-sensitive: the falling edge is latched, and the line can then be released.

A level-7 request that has been acknowledged is re-armed only after the line goes high and then low again, whatever the mask.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, `pend` is 0, `pend_lvl` is 0, `vec` is 0, and `vec_vld`, `avec_term` and `spurious` are all 0.
- R2: `pend_lvl` gives the number (1 to 7) of the highest eligible active level. `pend` is high whenever any level is eligible. `pend_lvl` is 0 when no level is eligible.
- R3: A level from 1 to 6 is eligible only when its number is strictly greater than `mask`. With `mask` equal to 7, none of levels 1 to 6 is ever pending.
- R4: An active level-7 request is pending for every `mask` value, 7 included.
- R5: After level 7 is acknowledged, level 7 stays non-pending while the line stays low. It becomes pending again one clock after the line is driven high and then low again.
- R6: An acknowledge is a one-clock `ack_strb` with the acknowledged level on `ack_addr` (address bits 3 to 1). The response appears in the clock after the sampling edge and lasts exactly one clock. An acknowledge with level 0 gives no response.
- R7: If an acknowledged level is active and not autovectored, the controller raises `vec_vld` and drives `vec` with the `dev_vec` byte. This is the vector taken from the low byte of the data bus.
- R8: A level is autovectored when its bit in `avec_cfg` is set (bit n-1 for level n) or when `avec_n` is low during the acknowledge. Acknowledging an active autovectored level raises `avec_term` with `vec` equal to 24 plus the level. `dev_vec` is not used in this case.
- R9: Acknowledging a level whose request is no longer active raises `spurious` with `vec` equal to 24. This covers a level-sensitive line that was released two or more clocks earlier.
- R10: With `edge_sel` bit n-1 set, a low pulse of at least 1.5 clocks on level n is latched and stays pending after the line is released. Acknowledging that level clears the latch.
- R11: `vec` is 0 in every clock in which none of the three response strobes is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low requests; bit n-1 is level n |
| mask | input | 3 | Current interrupt priority mask |
| edge_sel | input | 6 | Edge mode for levels 1 to 6 |
| avec_cfg | input | 7 | Per-level autovector configuration |
| avec_n | input | 1 | External autovector request, active low |
| ack_strb | input | 1 | Interrupt-acknowledge cycle strobe |
| ack_addr | input | 3 | CPU-space address bits 3 to 1 (level) |
| dev_vec | input | 8 | Vector byte from the data bus low byte |
| pend | output | 1 | An eligible request is pending |
| pend_lvl | output | 3 | Winning level, 0 when none |
| vec | output | 8 | Vector number of the response |
| vec_vld | output | 1 | Device vector returned (one clock) |
| avec_term | output | 1 | Autovector termination (one clock) |
| spurious | output | 1 | Spurious interrupt response (one clock) |

## Verification
A change on a request line is seen through exactly one register, so `pend` and `pend_lvl` are checked one rising edge after the line is driven. A mask change acts combinationally, so it is checked after the same single edge.

Acknowledge responses are registered once. They are sampled just after the edge that captured `ack_strb`, and checked again one edge later to confirm that they are gone and that `vec` has returned to 0.

The timing of the level-7 re-arm and of the spurious case depends on these one-edge delays:
- Each stimulus in those tests is followed by the exact number of edges that the requirement allows.
- A released level-sensitive line is given two edges before its acknowledge.

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       irq_n,
  input  logic [2:0]       mask,
  input  logic [5:0]       edge_sel,
  input  logic [6:0]       avec_cfg,
  input  logic             avec_n,
  input  logic             ack_strb,
  input  logic [3:1]       ack_addr,
  input  logic [VEC_W-1:0] dev_vec,
  output logic             pend,
  output logic [2:0]       pend_lvl,
  output logic [VEC_W-1:0] vec,
  output logic             vec_vld,
  output logic             avec_term,
  output logic             spurious
);
  localparam int NLVL = 7;

  logic [NLVL-1:0] s_low, neg_low, prev_hi, fall, ack_hit, active, eligible;
  logic [NLVL-2:0] elat;
  logic            arm7;
  logic            ack_ok;
  logic [2:0]      idx;

  assign ack_ok  = ack_strb && (ack_addr != 3'd0);
  assign idx     = ack_addr - 3'd1;
  assign ack_hit = ack_ok ? (NLVL'(1) << idx) : '0;
  assign fall    = (~irq_n | neg_low) & prev_hi;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) neg_low <= '0;
    else        neg_low <= ~irq_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_low   <= '0;
      prev_hi <= '1;
    end else begin
      s_low   <= ~irq_n;
      prev_hi <= irq_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) elat <= '0;
    else
      for (int i = 0; i < NLVL-1; i++)
        elat[i] <= edge_sel[i] & (fall[i] | (elat[i] & ~ack_hit[i]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             arm7 <= 1'b1;
    else if (ack_hit[6])    arm7 <= 1'b0;
    else if (irq_n[6])      arm7 <= 1'b1;

  always_comb begin
    for (int i = 0; i < NLVL-1; i++) begin
      active[i]   = edge_sel[i] ? elat[i] : s_low[i];
      eligible[i] = active[i] && (3'(i + 1) > mask);
    end
    active[6]   = s_low[6] & arm7;
    eligible[6] = active[6];
  end

  always_comb begin
    pend_lvl = 3'd0;
    for (int i = 0; i < NLVL; i++)
      if (eligible[i]) pend_lvl = 3'(i + 1);
  end

  assign pend = |eligible;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vec       <= '0;
      vec_vld   <= 1'b0;
      avec_term <= 1'b0;
      spurious  <= 1'b0;
    end else begin
      vec       <= '0;
      vec_vld   <= 1'b0;
      avec_term <= 1'b0;
      spurious  <= 1'b0;
      if (ack_ok) begin
        if (!active[idx]) begin
          spurious <= 1'b1;
          vec      <= VEC_W'(SPUR_VEC);
        end else if (avec_cfg[idx] || !avec_n) begin
          avec_term <= 1'b1;
          vec       <= VEC_W'(AUTO_BASE) + VEC_W'(ack_addr);
        end else begin
          vec_vld <= 1'b1;
          vec     <= dev_vec;
        end
      end
    end
endmodule

module irq_ack_ctrl_chk #(
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mask,
  input logic             ack_strb,
  input logic [3:1]       ack_addr,
  input logic [VEC_W-1:0] dev_vec,
  input logic             pend,
  input logic [2:0]       pend_lvl,
  input logic [VEC_W-1:0] vec,
  input logic             vec_vld,
  input logic             avec_term,
  input logic             spurious
);
  logic any_resp;
  assign any_resp = vec_vld | avec_term | spurious;

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({vec_vld, avec_term, spurious}) <= 1); // R6
  AST_RESP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    any_resp |-> $past(ack_strb && ack_addr != 3'd0)); // R6
  AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strb && ack_addr != 3'd0) |=> any_resp); // R6
  AST_DEV_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> vec == $past(dev_vec)); // R7
  AST_AUTO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    avec_term |-> vec == VEC_W'(AUTO_BASE) + VEC_W'($past(ack_addr))); // R8
  AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> vec == VEC_W'(SPUR_VEC)); // R9
  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pend_lvl != 3'd7) |-> pend_lvl > mask); // R3
  AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    pend == (pend_lvl != 3'd0)); // R2
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_resp |-> vec == '0); // R11
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(
  .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mask(mask), .ack_strb(ack_strb),
  .ack_addr(ack_addr), .dev_vec(dev_vec), .pend(pend), .pend_lvl(pend_lvl),
  .vec(vec), .vec_vld(vec_vld), .avec_term(avec_term), .spurious(spurious)
);

// File: tb/test_irq_ack_ctrl.sv
`timescale 1ns/1ps
module test_irq_ack_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_n = 7'h7F;
  logic [2:0] mask = 3'd0;
  logic [5:0] edge_sel = '0;
  logic [6:0] avec_cfg = '0;
  logic       avec_n = 1'b1;
  logic       ack_strb = 1'b0;
  logic [3:1] ack_addr = 3'd0;
  logic [7:0] dev_vec = 8'h00;
  logic       pend;
  logic [2:0] pend_lvl;
  logic [7:0] vec;
  logic       vec_vld, avec_term, spurious;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_ack_ctrl i_irq_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .mask(mask), .edge_sel(edge_sel),
    .avec_cfg(avec_cfg), .avec_n(avec_n), .ack_strb(ack_strb), .ack_addr(ack_addr),
    .dev_vec(dev_vec), .pend(pend), .pend_lvl(pend_lvl), .vec(vec),
    .vec_vld(vec_vld), .avec_term(avec_term), .spurious(spurious)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_pend(string tag, int p, int l);
    chk({tag, " pend"}, int'(pend), p);
    chk({tag, " pend_lvl"}, int'(pend_lvl), l);
  endtask

  // kind: 0 none, 1 device vector, 2 autovector, 3 spurious
  task automatic do_ack(string tag, logic [2:0] lvl, int kind, int exp_vec);
    ack_strb = 1'b1;
    ack_addr = lvl;
    step();
    ack_strb = 1'b0;
    ack_addr = 3'd0;
    chk({tag, " vec_vld"}, int'(vec_vld), int'(kind == 1));
    chk({tag, " avec_term"}, int'(avec_term), int'(kind == 2));
    chk({tag, " spurious"}, int'(spurious), int'(kind == 3));
    chk({tag, " vec"}, int'(vec), exp_vec);
  endtask

  task automatic t_reset;
    chk_pend("R1 reset", 0, 0);
    chk("R1 reset vec", int'(vec), 0);
    chk("R1 reset strobes", int'({vec_vld, avec_term, spurious}), 0);
  endtask

  task automatic t_priority;
    irq_n[1] = 1'b0; irq_n[4] = 1'b0;
    step();
    chk_pend("R2 levels 2+5", 1, 5);
    irq_n[2] = 1'b0;
    step();
    chk_pend("R2 levels 2+3+5", 1, 5);
    irq_n[4] = 1'b1;
    step();
    chk_pend("R2 levels 2+3", 1, 3);
    irq_n = 7'h7F;
    step();
    chk_pend("R2 none", 0, 0);
  endtask

  task automatic t_mask;
    irq_n[2] = 1'b0;
    mask = 3'd3;
    step();
    chk_pend("R3 level3 mask3", 0, 0);
    mask = 3'd2;
    step();
    chk_pend("R3 level3 mask2", 1, 3);
    irq_n[5] = 1'b0;
    mask = 3'd7;
    step();
    chk_pend("R3 levels 3+6 mask7", 0, 0);
    irq_n = 7'h7F;
    mask = 3'd0;
    step();
  endtask

  task automatic t_nmi;
    mask = 3'd7;
    irq_n[6] = 1'b0;
    irq_n[3] = 1'b0;
    step();
    chk_pend("R4 level7 mask7", 1, 7);
    dev_vec = 8'h40;
    do_ack("R7 level7 ack", 3'd7, 1, 8'h40);
    chk_pend("R5 after ack", 0, 0);
    step(3);
    chk_pend("R5 held low", 0, 0);
    irq_n[6] = 1'b1;
    step();
    chk_pend("R5 negated", 0, 0);
    irq_n[6] = 1'b0;
    step();
    chk_pend("R5 reasserted", 1, 7);
    irq_n = 7'h7F;
    mask = 3'd0;
    step();
  endtask

  task automatic t_ack_dev;
    irq_n[3] = 1'b0;
    dev_vec = 8'hA5;
    step();
    do_ack("R7 level4 device", 3'd4, 1, 8'hA5);
    step();
    chk("R6 one clock wide", int'({vec_vld, avec_term, spurious}), 0);
    chk("R11 vec idle", int'(vec), 0);
    do_ack("R6 level0 ignored", 3'd0, 0, 0);
    irq_n = 7'h7F;
    step();
  endtask

  task automatic t_autovec;
    avec_cfg[1] = 1'b1;
    irq_n[1] = 1'b0;
    dev_vec = 8'h77;
    step();
    do_ack("R8 cfg level2", 3'd2, 2, 26);
    avec_cfg = '0;
    irq_n = 7'h7F;
    irq_n[5] = 1'b0;
    step();
    avec_n = 1'b0;
    do_ack("R8 pin level6", 3'd6, 2, 30);
    avec_n = 1'b1;
    irq_n = 7'h7F;
    step();
  endtask

  task automatic t_spurious;
    irq_n[4] = 1'b0;
    dev_vec = 8'h99;
    step(2);
    chk_pend("R9 level5 up", 1, 5);
    irq_n[4] = 1'b1;
    step(2);
    do_ack("R9 dropped level5", 3'd5, 3, 24);
  endtask

  task automatic t_edge;
    edge_sel[2] = 1'b1;
    dev_vec = 8'h3C;
    step();
    irq_n[2] = 1'b0;
    #7.5;
    irq_n[2] = 1'b1;
    step(2);
    chk_pend("R10 latched after release", 1, 3);
    step(3);
    chk_pend("R10 still latched", 1, 3);
    do_ack("R10 edge ack", 3'd3, 1, 8'h3C);
    chk_pend("R10 cleared by ack", 0, 0);
    edge_sel = '0;
    step();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_priority();
    t_mask();
    t_nmi();
    t_ack_dev();
    t_autovec();
    t_spurious();
    t_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule